// File: doc/BRIEF.md
# Byte-per-pin GPIO register bank

This block maps a large array of general-purpose pins onto a plain synchronous register bus. The pins are grouped into ports of equal width. Every pin has its own byte in the address space. Software can therefore drive or sample one pin with a single byte access, with no read-modify-write of a shared port word. Each port also has one 32-bit word that holds the direction of all of its pins.

The pad side is split into three vectors: a raw input vector, an output-level vector and an output-enable vector. Raw inputs pass through a two-flop synchronizer before the bus can read them. The output level comes straight from the per-pin latches and the enable comes straight from the direction words. A level written while a pin is still an input is therefore driven as soon as that pin's direction bit is set.

Top module: `gpio_bank_map`

## Requirements
- R1: After reset every direction bit and every output latch is 0, so `pinOe` and `pinOut` are all zero and a direction-word read returns 0.
- R2: A write to byte offset n, with n below 256 and pin n = port*32 + bit, loads bit 0 of `busWdata` into the output latch of pin n. `pinOut[n]` shows the new level one cycle after the write, and no other latch changes.
- R3: A read of byte offset n returns the synchronized level of `pinIn[n]` in bit 0 of `busRdata` (1 = high, 0 = low), with bits 31:1 zero. The read data is registered and is valid in the cycle after the address is presented.
- R4: `pinIn` passes through two flops before the read mux. A pin change made just before clock edge e0 is still seen as the old level by a read captured at edge e1, and as the new level by a read captured at edge e2.
- R5: The direction word of port p sits at byte offset 0x2000 + 4*p, which must be word aligned. Writing it stores all 32 bits of `busWdata` and reading it returns them. Bit b of the word drives `pinOe[p*32+b]`, where 1 means output and 0 means input, one cycle after the write.
- R6: `pinOut[n]` follows the output latch whatever the direction. A level latched while the pin is an input appears with `pinOe[n]` in the cycle after the direction bit is set.
- R7: Reads of unmapped offsets return 0, and writes to them change no latch and no direction bit. Unmapped offsets are 0x100 to 0x1FFF, 0x2020 and above, and any direction offset that is not word aligned.
- R8: A pin-byte write uses only bit 0 of the data. A value of 0xFE clears the latch and 0x03 sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 14 | Byte address of the access |
| busWe | input | 1 | Write strobe for the current cycle |
| busWdata | input | 32 | Write data: bit 0 for pin bytes, all bits for direction words |
| busRdata | output | 32 | Registered read data for the previous cycle's address |
| pinIn | input | 256 | Raw pad input levels |
| pinOut | output | 256 | Output level of each pin latch |
| pinOe | output | 256 | Output enable of each pin, taken from the direction words |

## Verification
The assertions assume that `busAddr`, `busWe` and `busWdata` are stable around each rising edge and that a write lasts a single cycle. The bench drives every input at the falling edge and drops `busWe` after one cycle. The assertions also take `pinIn` to be asynchronous, so nothing is claimed about its value before the two synchronizer flops. The bench only changes `pinIn` at falling edges and counts whole cycles before it expects a new level to be read back.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NUM_PORTS = 8;
  localparam int PORT_PINS = 32;
  localparam int ADDR_W = 14;
  localparam int DATA_W = PORT_PINS;
  localparam int PIN_COUNT = NUM_PORTS * PORT_PINS;
  localparam int PIN_IDX_W = $clog2(PIN_COUNT);
  localparam int PORT_IDX_W = $clog2(NUM_PORTS);
  localparam logic [ADDR_W-1:0] DIR_BASE = ADDR_W'('h2000);
  localparam logic [ADDR_W-1:0] DIR_END = DIR_BASE + ADDR_W'(4 * NUM_PORTS);

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PIN  = 2'd1,
    RD_DIR  = 2'd2
  } rd_sel_e;

  typedef struct packed {
    logic pinWe;
    logic dirWe;
    logic [PIN_IDX_W-1:0] pinIdx;
    logic [PORT_IDX_W-1:0] portIdx;
    rd_sel_e rdSel;
  } bus_strobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic busWe,
  output bus_strobe_t strobe
);
  logic isPin;
  logic isDir;
  logic [ADDR_W-1:0] dirOffset;

  always_comb begin
    dirOffset = busAddr - DIR_BASE;
    isPin = (busAddr < ADDR_W'(PIN_COUNT));
    isDir = (busAddr >= DIR_BASE) && (busAddr < DIR_END) && (busAddr[1:0] == 2'b00);
    strobe.pinWe = busWe && isPin;
    strobe.dirWe = busWe && isDir;
    strobe.pinIdx = busAddr[PIN_IDX_W-1:0];
    strobe.portIdx = dirOffset[PORT_IDX_W+1:2];
    if (isPin) strobe.rdSel = RD_PIN;
    else if (isDir) strobe.rdSel = RD_DIR;
    else strobe.rdSel = RD_NONE;
  end

  // R5 / R2: a write targets at most one register kind
  a_r5_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.pinWe, strobe.dirWe}));

  // R7: unmapped addresses never produce a write strobe
  a_r7_unmapped_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdSel == RD_NONE) |-> !(strobe.pinWe || strobe.dirWe));
endmodule

// File: rtl/gpio_bank_data.sv
module gpio_bank_data
  import gpio_bank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  bus_strobe_t strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [DATA_W-1:0] busRdata,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe
);
  logic [PIN_COUNT-1:0] syncA;
  logic [PIN_COUNT-1:0] syncB;
  logic [PIN_COUNT-1:0] outLatch;
  logic [PIN_COUNT-1:0] dirFlat;
  logic [DATA_W-1:0] rdNext;

  // two-flop input synchronizer
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  // per-pin output latches
  always_ff @(posedge clk) begin
    if (rst) outLatch <= '0;
    else if (strobe.pinWe) outLatch[strobe.pinIdx] <= busWdata[0];
  end

  // one direction word per port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dir
    always_ff @(posedge clk) begin
      if (rst) dirFlat[p*PORT_PINS +: PORT_PINS] <= '0;
      else if (strobe.dirWe && (strobe.portIdx == PORT_IDX_W'(p)))
        dirFlat[p*PORT_PINS +: PORT_PINS] <= busWdata;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_PIN:  rdNext = {{(DATA_W-1){1'b0}}, syncB[strobe.pinIdx]};
      RD_DIR:  rdNext = dirFlat[strobe.portIdx*PORT_PINS +: PORT_PINS];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) busRdata <= '0;
    else busRdata <= rdNext;
  end

  assign pinOut = outLatch;
  assign pinOe = dirFlat;

  a_r2_pin_write: assert property (@(posedge clk) disable iff (rst)
    strobe.pinWe |=> (pinOut[$past(strobe.pinIdx)] == $past(busWdata[0])));

  a_r5_dir_write: assert property (@(posedge clk) disable iff (rst)
    strobe.dirWe |=> (pinOe[$past(strobe.portIdx)*PORT_PINS +: PORT_PINS] == $past(busWdata)));

  a_r3_pin_read_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdSel == RD_PIN) |=> (busRdata[DATA_W-1:1] == '0));

  a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdSel == RD_NONE) |=> (busRdata == '0));

  a_r7_no_write_stable: assert property (@(posedge clk) disable iff (rst)
    !(strobe.pinWe || strobe.dirWe) |=> ($stable(pinOut) && $stable(pinOe)));
endmodule

// File: rtl/gpio_bank_map.sv
module gpio_bank_map
  import gpio_bank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe
);
  bus_strobe_t strobe;

  gpio_bank_ctrl ctrl_i (
    .clk(clk),
    .rst(rst),
    .busAddr(busAddr),
    .busWe(busWe),
    .strobe(strobe)
  );

  gpio_bank_data data_i (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .busWdata(busWdata),
    .pinIn(pinIn),
    .busRdata(busRdata),
    .pinOut(pinOut),
    .pinOe(pinOe)
  );
endmodule

// File: tb/gpio_bank_map_tb_top.sv
module gpio_bank_map_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [13:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [255:0] pinIn = '0;
  logic [255:0] pinOut;
  logic [255:0] pinOe;

  logic [255:0] expOut = '0;
  logic [255:0] expOe = '0;
  int nChecks = 0;
  int nFails = 0;

  typedef struct {
    logic [31:0] exp;
    string tag;
  } rd_item_t;
  rd_item_t rdQ[$];

  always #5 clk = ~clk;

  gpio_bank_map dut_i (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [13:0] addr, logic [31:0] data);
    @(negedge clk);
    busAddr = addr;
    busWe = 1'b1;
    busWdata = data;
    @(negedge clk);
    busWe = 1'b0;
    if (addr < 14'd256) expOut[addr[7:0]] = data[0];
    else if (addr >= 14'h2000 && addr < 14'h2020 && addr[1:0] == 2'b00)
      expOe[(int'(addr - 14'h2000) / 4) * 32 +: 32] = data;
  endtask

  task automatic rd(logic [13:0] addr, logic [31:0] exp, string tag);
    rd_item_t it;
    @(negedge clk);
    busAddr = addr;
    busWe = 1'b0;
    it.exp = exp;
    it.tag = tag;
    rdQ.push_back(it);
  endtask

  // monitor: compares each queued read against the registered read data
  initial begin
    forever begin
      rd_item_t it;
      wait (rdQ.size() != 0);
      @(posedge clk);
      #1;
      it = rdQ.pop_front();
      check(it.tag, {224'b0, busRdata}, {224'b0, it.exp});
    end
  end

  logic done = 1'b0;
  initial begin
    #1000000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pinOe after reset", pinOe, '0);
    check("R1 pinOut after reset", pinOut, '0);
    rd(14'h2000, 32'h0, "R1 dir port0 reset");
    rd(14'h201C, 32'h0, "R1 dir port7 reset");

    // R5 direction words
    wr(14'h2008, 32'hA5A5_0F0F);
    check("R5 pinOe port2", pinOe, expOe);
    wr(14'h201C, 32'h8000_0001);
    check("R5 pinOe port7", pinOe, expOe);
    rd(14'h2008, 32'hA5A5_0F0F, "R5 read port2");
    rd(14'h201C, 32'h8000_0001, "R5 read port7");
    rd(14'h2004, 32'h0, "R5 read port1 untouched");

    // R2 pin latches
    wr(14'd70, 32'h1);
    check("R2 pin70 set", pinOut, expOut);
    wr(14'd255, 32'h1);
    wr(14'd0, 32'h1);
    check("R2 pins 0 255 set", pinOut, expOut);
    wr(14'd70, 32'h0);
    check("R2 pin70 cleared others kept", pinOut, expOut);

    // R8 only bit 0 matters
    wr(14'd10, 32'h1);
    wr(14'd10, 32'hFE);
    check("R8 0xFE clears", pinOut, expOut);
    wr(14'd10, 32'h03);
    check("R8 0x03 sets", pinOut, expOut);

    // R6 latch before direction
    wr(14'd33, 32'h1);
    check("R6 latched while input pinOut", {255'b0, pinOut[33]}, 256'd1);
    check("R6 latched while input pinOe", {255'b0, pinOe[33]}, 256'd0);
    wr(14'h2004, 32'h0000_0002);
    check("R6 enable shows latched level", {254'b0, pinOe[33], pinOut[33]}, 256'd3);

    // R3 pin reads through synchronizer
    @(negedge clk);
    pinIn = '0;
    pinIn[5] = 1'b1;
    pinIn[100] = 1'b1;
    pinIn[255] = 1'b1;
    repeat (3) @(negedge clk);
    rd(14'd5, 32'h1, "R3 pin5 high");
    rd(14'd6, 32'h0, "R3 pin6 low");
    rd(14'd100, 32'h1, "R3 pin100 high");
    rd(14'd255, 32'h1, "R3 pin255 high");
    rd(14'd254, 32'h0, "R3 pin254 low");

    // R4 synchronizer latency
    @(negedge clk);
    pinIn[20] = 1'b1;
    rd(14'd20, 32'h0, "R4 one edge after change old level");
    rd(14'd20, 32'h1, "R4 two edges after change new level");

    // R7 unmapped offsets
    rd(14'h0100, 32'h0, "R7 read 0x100");
    rd(14'h1FFF, 32'h0, "R7 read 0x1FFF");
    rd(14'h2020, 32'h0, "R7 read 0x2020");
    rd(14'h200A, 32'h0, "R7 read misaligned dir");
    wr(14'h2009, 32'hFFFF_FFFF);
    wr(14'h0100, 32'h1);
    wr(14'h3000, 32'hFFFF_FFFF);
    check("R7 writes ignored pinOe", pinOe, expOe);
    check("R7 writes ignored pinOut", pinOut, expOut);
    rd(14'h2008, 32'hA5A5_0F0F, "R7 port2 word unchanged");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule